// File: doc/BRIEF.md
# Supply-Guarded SRAM Address Gate

This block stands between a byte-wide host bus and a 128K×8 external static RAM. Every host access is decoded against a small register window at the bottom of the address map. Accesses inside the window go to an on-chip bank of byte registers, and the external RAM never sees a strobe for them. Accesses outside the window are passed through to the RAM as active-low chip-enable, output-enable and write-enable.

A digital supply-good input guards the block. While it is low, no external strobe is asserted and no register write is accepted. Once the supply comes back, nothing is granted until the host has released its chip-enable for at least one clock. This keeps a half-finished access from resuming across a power dip.

All host inputs are sampled on the clock and all outputs are registered, so each strobe follows its inputs by one cycle. A register write is committed on the clock where the host write-enable is seen rising.

Top module: `sram_gate_decoder`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `ram_ce_n`, `ram_oe_n` and `ram_we_n` are 1, `reg_oe` is 0 and `reg_rdata` is 0.
- R2: An address with bits 16..6 all zero (0x00000–0x0003F) never drives `ram_ce_n`, `ram_oe_n` or `ram_we_n` low, whatever the host strobes are.
- R3: For an address of 0x00040 or above, with supply granted, `ram_ce_n` equals `host_ce_n` one cycle later, and `ram_oe_n` is 0 exactly when `host_ce_n` and `host_oe_n` were both 0 one cycle earlier.
- R4: `ram_we_n` is 0 exactly when an external access was granted and `host_we_n` was 0 one cycle earlier.
- R5: A register write happens on the clock where `host_we_n` is seen at 1 after having been 0. It requires `host_ce_n` = 0, an in-window address and a granted supply. The register index is address bits 5..0. An in-window read (`host_ce_n` = `host_oe_n` = 0) returns that register on `reg_rdata` with `reg_oe` = 1 one cycle later.
- R6: While `supply_ok` is 0, all three external strobes are 1 on the next cycle, and a register write is dropped even if its write-enable edge falls on that cycle.
- R7: After `supply_ok` returns to 1 while `host_ce_n` is still 0, the external strobes stay inactive. The register window also stays closed. This holds until a cycle with `host_ce_n` = 1 and `supply_ok` = 1 has been seen.
- R8: The window edge is exact: 0x0003F is internal, 0x00040 and 0x1FFFF are external.
- R9: A write-enable edge seen while `host_ce_n` = 1 writes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| host_addr | input | 17 | Host byte address |
| host_wdata | input | 8 | Host write data |
| host_ce_n | input | 1 | Host chip-enable, active low |
| host_oe_n | input | 1 | Host output-enable, active low |
| host_we_n | input | 1 | Host write-enable, active low |
| supply_ok | input | 1 | Supply within tolerance |
| ram_ce_n | output | 1 | External RAM chip-enable, active low |
| ram_oe_n | output | 1 | External RAM output-enable, active low |
| ram_we_n | output | 1 | External RAM write-enable, active low |
| reg_rdata | output | 8 | Register window read data |
| reg_oe | output | 1 | Register read data valid |

## Verification
The register commit on a rising write-enable and the loss of supply can fall on the same clock. The bench provokes this by raising `host_we_n` and dropping `supply_ok` at the same time during a window write. It then restores the supply, cycles chip-enable and reads the register back. The old value is expected, and every external strobe must have stayed high throughout. A second case lets the supply return while chip-enable is still held low, and judges that both the RAM strobes and the register path stay closed until chip-enable is released.

// File: rtl/sgd_pkg.sv
package sgd_pkg;
  typedef struct packed {
    logic ce_n;
    logic oe_n;
    logic we_n;
  } ram_strobe_t;

  localparam ram_strobe_t STROBE_IDLE = '{ce_n: 1'b1, oe_n: 1'b1, we_n: 1'b1};
endpackage

// File: rtl/sgd_window_decode.sv
module sgd_window_decode #(
  parameter int ADDR_W   = 17,
  parameter int WIN_BITS = 6
) (
  input  logic [ADDR_W-1:0]   addr,
  output logic                in_win,
  output logic [WIN_BITS-1:0] idx
);
  localparam int HI_W = ADDR_W - WIN_BITS;

  // window is the lowest 2**WIN_BITS bytes
  assign in_win = (addr[ADDR_W-1:WIN_BITS] == {HI_W{1'b0}});
  assign idx    = addr[WIN_BITS-1:0];
endmodule

// File: rtl/sgd_supply_guard.sv
module sgd_supply_guard (
  input  logic clk,
  input  logic rst,
  input  logic supply_ok,
  input  logic host_ce_n,
  output logic grant
);
  logic session_q;

  // session opens only on an idle bus with good supply; any dip closes it
  always_ff @(posedge clk) begin
    if (rst) session_q <= 1'b0;
    else     session_q <= supply_ok & (session_q | host_ce_n);
  end

  assign grant = session_q & supply_ok;

  a_r7_closed_after_dip: assert property (@(posedge clk) disable iff (rst)
    !supply_ok |=> !session_q);
endmodule

// File: rtl/sgd_reg_bank.sv
module sgd_reg_bank #(
  parameter int DATA_W   = 8,
  parameter int WIN_BITS = 6
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic [WIN_BITS-1:0] wr_idx,
  input  logic [DATA_W-1:0]   wr_data,
  input  logic                rd_en,
  input  logic [WIN_BITS-1:0] rd_idx,
  output logic [DATA_W-1:0]   rd_data
);
  localparam int DEPTH = 1 << WIN_BITS;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst)        rd_data <= '0;
    else if (rd_en) rd_data <= mem[rd_idx];
  end
endmodule

// File: rtl/sram_gate_decoder.sv
module sram_gate_decoder #(
  parameter int ADDR_W   = 17,
  parameter int DATA_W   = 8,
  parameter int WIN_BITS = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  input  logic              host_ce_n,
  input  logic              host_oe_n,
  input  logic              host_we_n,
  input  logic              supply_ok,
  output logic              ram_ce_n,
  output logic              ram_oe_n,
  output logic              ram_we_n,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              reg_oe
);
  import sgd_pkg::*;

  logic                in_win;
  logic [WIN_BITS-1:0] idx;
  logic                grant;
  logic                we_prev_q;
  logic                acc_ext, acc_reg, reg_wr, reg_rd;
  ram_strobe_t         strobe_q;

  sgd_window_decode #(.ADDR_W(ADDR_W), .WIN_BITS(WIN_BITS)) u_dec (
    .addr(host_addr), .in_win(in_win), .idx(idx));

  sgd_supply_guard u_guard (
    .clk(clk), .rst(rst), .supply_ok(supply_ok),
    .host_ce_n(host_ce_n), .grant(grant));

  assign acc_ext = grant & ~host_ce_n & ~in_win;
  assign acc_reg = grant & ~host_ce_n &  in_win;
  assign reg_wr  = acc_reg & ~we_prev_q & host_we_n;
  assign reg_rd  = acc_reg & ~host_oe_n;

  sgd_reg_bank #(.DATA_W(DATA_W), .WIN_BITS(WIN_BITS)) u_bank (
    .clk(clk), .rst(rst),
    .wr_en(reg_wr), .wr_idx(idx), .wr_data(host_wdata),
    .rd_en(reg_rd), .rd_idx(idx), .rd_data(reg_rdata));

  always_ff @(posedge clk) begin
    if (rst) begin
      strobe_q  <= STROBE_IDLE;
      we_prev_q <= 1'b1;
      reg_oe    <= 1'b0;
    end else begin
      strobe_q.ce_n <= ~acc_ext;
      strobe_q.oe_n <= ~(acc_ext & ~host_oe_n);
      strobe_q.we_n <= ~(acc_ext & ~host_we_n);
      we_prev_q     <= host_we_n;
      reg_oe        <= reg_rd;
    end
  end

  assign ram_ce_n = strobe_q.ce_n;
  assign ram_oe_n = strobe_q.oe_n;
  assign ram_we_n = strobe_q.we_n;

  a_r2_window_quiet: assert property (@(posedge clk) disable iff (rst)
    in_win |=> (ram_ce_n && ram_oe_n && ram_we_n));
  a_r3_oe_within_ce: assert property (@(posedge clk) disable iff (rst)
    !ram_oe_n |-> !ram_ce_n);
  a_r4_we_within_ce: assert property (@(posedge clk) disable iff (rst)
    !ram_we_n |-> !ram_ce_n);
  a_r5_one_reader: assert property (@(posedge clk) disable iff (rst)
    !(reg_oe && !ram_oe_n));
  a_r6_supply_blocks: assert property (@(posedge clk) disable iff (rst)
    !supply_ok |=> (ram_ce_n && ram_oe_n && ram_we_n));
  a_r7_no_resume: assert property (@(posedge clk) disable iff (rst)
    (supply_ok && !$past(supply_ok) && !host_ce_n) |=> (ram_ce_n && !reg_oe));
endmodule

// File: tb/sim_sram_gate_decoder.sv
module sim_sram_gate_decoder;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic [16:0] host_addr;
  logic [7:0]  host_wdata;
  logic        host_ce_n, host_oe_n, host_we_n, supply_ok;
  logic        ram_ce_n, ram_oe_n, ram_we_n, reg_oe;
  logic [7:0]  reg_rdata;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sram_gate_decoder u0 (
    .clk(clk), .rst(rst), .host_addr(host_addr), .host_wdata(host_wdata),
    .host_ce_n(host_ce_n), .host_oe_n(host_oe_n), .host_we_n(host_we_n),
    .supply_ok(supply_ok), .ram_ce_n(ram_ce_n), .ram_oe_n(ram_oe_n),
    .ram_we_n(ram_we_n), .reg_rdata(reg_rdata), .reg_oe(reg_oe));

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    host_ce_n = 1; host_oe_n = 1; host_we_n = 1;
    step();
  endtask

  task automatic strobes(string req, logic ce, logic oe, logic we);
    chk(req, {13'd0, ram_ce_n, ram_oe_n, ram_we_n}, {13'd0, ce, oe, we});
  endtask

  task automatic wr_cycle(logic [16:0] a, logic [7:0] d, logic drop_at_edge);
    host_addr = a; host_wdata = d; host_ce_n = 0; host_we_n = 0;
    step();
    host_we_n = 1;
    if (drop_at_edge) supply_ok = 0;
    step();
    host_ce_n = 1;
    step();
  endtask

  task automatic rd_check(string req, logic [16:0] a, logic [7:0] exp);
    host_addr = a; host_ce_n = 0; host_oe_n = 0;
    step();
    chk(req, {15'd0, reg_oe}, 16'd1);
    chk(req, {8'd0, reg_rdata}, {8'd0, exp});
    strobes(req, 1, 1, 1);
    idle();
  endtask

  task automatic t_reset();
    rst = 1;
    step(); step();
    strobes("R1", 1, 1, 1);
    chk("R1", {15'd0, reg_oe}, 16'd0);
    chk("R1", {8'd0, reg_rdata}, 16'd0);
    rst = 0;
    step();
    strobes("R1", 1, 1, 1);
    idle();
  endtask

  task automatic t_window();
    host_addr = 17'h00010; host_ce_n = 0; host_oe_n = 0; host_we_n = 0;
    step();
    strobes("R2", 1, 1, 1);
    idle();
    wr_cycle(17'h00005, 8'hA5, 0);
    rd_check("R5", 17'h00005, 8'hA5);
    wr_cycle(17'h0003F, 8'h3C, 0);
    rd_check("R8", 17'h0003F, 8'h3C);
    rd_check("R5", 17'h00005, 8'hA5);
  endtask

  task automatic t_external();
    host_addr = 17'h00040; host_ce_n = 0; host_oe_n = 0;
    step();
    strobes("R8", 0, 0, 1);
    chk("R3", {15'd0, reg_oe}, 16'd0);
    host_addr = 17'h1FFFF; host_oe_n = 1; host_we_n = 0;
    step();
    strobes("R4", 0, 1, 0);
    host_we_n = 1;
    step();
    strobes("R3", 0, 1, 1);
    host_ce_n = 1; host_oe_n = 0;
    step();
    strobes("R3", 1, 1, 1);
    idle();
  endtask

  task automatic t_ce_high_write();
    host_addr = 17'h00005; host_wdata = 8'h11; host_ce_n = 1; host_we_n = 0;
    step();
    host_we_n = 1;
    step();
    rd_check("R9", 17'h00005, 8'hA5);
  endtask

  task automatic t_supply_drop();
    host_addr = 17'h00100; host_ce_n = 0; host_oe_n = 0;
    step();
    strobes("R3", 0, 0, 1);
    supply_ok = 0;
    step();
    strobes("R6", 1, 1, 1);
    host_ce_n = 1; host_oe_n = 1;
    step();
    supply_ok = 1;
    step();
    wr_cycle(17'h00005, 8'h77, 1);
    strobes("R6", 1, 1, 1);
    supply_ok = 1;
    step();
    rd_check("R6", 17'h00005, 8'hA5);
  endtask

  task automatic t_relock();
    host_addr = 17'h00200; host_ce_n = 0; host_oe_n = 0;
    supply_ok = 0;
    step();
    supply_ok = 1;
    step();
    strobes("R7", 1, 1, 1);
    step();
    strobes("R7", 1, 1, 1);
    host_addr = 17'h00005;
    step();
    chk("R7", {15'd0, reg_oe}, 16'd0);
    host_ce_n = 1; host_oe_n = 1;
    step();
    host_addr = 17'h00200; host_ce_n = 0; host_oe_n = 0;
    step();
    strobes("R7", 0, 0, 1);
    idle();
  endtask

  initial begin
    rst = 1; supply_ok = 1;
    host_addr = '0; host_wdata = '0;
    host_ce_n = 1; host_oe_n = 1; host_we_n = 1;
    @(negedge clk);
    t_reset();
    t_window();
    t_external();
    t_ce_high_write();
    t_supply_drop();
    t_relock();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 5000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule